// File: doc/BRIEF.md
# Linked-Ring Receive DMA Writer

This block takes received frames as a byte stream and writes each one into memory. The memory area comes from the receive descriptor that the engine currently holds in a circular linked ring. Each descriptor is four 32-bit words. It gives ownership, the usable buffer size, the buffer address and the address of the following descriptor. Bytes are packed little-endian into whole 32-bit words and written through a single word-wide memory port. When a frame ends, the engine writes a status word back into the descriptor. That word holds the received length and a truncation flag, and its ownership bit is cleared so that software can take the buffer.

Software builds the ring with the ownership bit set in every descriptor, places the address of the first descriptor on the ring base input, and raises the run input. If a frame starts while the current descriptor still belongs to software, the whole frame is discarded and a one-cycle drop pulse is raised. The engine keeps re-reading that descriptor until software hands it back. Bytes beyond the usable buffer size are discarded. The reported length is then clamped to that size and the truncation flag is set.

Top module: `rxdma_writer`

## Requirements
- R1: After reset, in_ready_o, mem_req_o and rx_drop_o are low. While the engine is idle it makes no memory access. When run_i is high in the idle state, the engine loads ring_base_i as the current descriptor address and starts fetching there.
- R2: A descriptor is four words at byte offsets +0 status (bit 31 = owned by the engine), +4 control (bits 13:0 = usable buffer size in bytes), +8 buffer byte address and +12 next descriptor address. Every descriptor read falls within these four words of the current descriptor.
- R3: Bytes are stored little-endian. Byte k of a frame goes to the word at buffer address + 4*(k/4), in bits 8*(k%4)+7 down to 8*(k%4). A partly filled final word is written with its unused upper bytes as zero.
- R4: After the last data word, the engine writes the descriptor status word. Bit 31 = 0, bits 29:16 = length, bit 0 = truncation flag, and all other bits are 0.
- R5: Short frames, including frames under 64 bytes, report their true byte count as the length.
- R6: Bytes at index >= buffer size are not written, and no data word is written at or beyond the size. In that case the length equals the size and bit 0 is 1. A frame of exactly the buffer size reports bit 0 = 0.
- R7: If the first byte of a frame arrives while the current descriptor has bit 31 = 0, the engine writes nothing for that frame and does not advance. rx_drop_o is high for exactly the one cycle after that first byte is accepted.
- R8: After a status write, the engine moves to the descriptor named by the next field. A ring whose last next field points to the first descriptor wraps around.
- R9: If run_i is low when the engine would start a new descriptor fetch, or while it waits between frames, it goes idle. A later high level on run_i restarts it at ring_base_i.
- R10: in_ready_o is low during every descriptor read and every status write. Bytes are accepted only in cycles where in_valid_i and in_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Receive engine run enable |
| ring_base_i | input | AW | Byte address of the first descriptor |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte stream data |
| in_last_i | input | 1 | Marks the final byte of a frame |
| in_ready_o | output | 1 | Byte accepted when high together with in_valid_i |
| rx_drop_o | output | 1 | One-cycle pulse for a frame dropped on a software-owned descriptor |
| mem_req_o | output | 1 | Memory access request, one word per cycle |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |

## Verification
On every cycle, the embedded properties check the following: the engine is silent while idle, input is stalled during descriptor reads and status writes, data writes stay below the buffer size, no write happens during a dropped frame, the drop pulse lasts a single cycle, and the released status never reports a length beyond the size. Other behaviour can only be shown by the bench's scenarios, where a behavioural model predicts every memory access and the drop pulse. These cover the byte packing and zero fill of the last word, the exact-size and truncated lengths, a short frame, a ring that wraps, a drop followed by a retry into the same descriptor after software returns it, and a stop and restart at a new base.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 14;
  localparam int unsigned LEN_LSB   = 16;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned TRUNC_BIT = 0;
  localparam int unsigned DESC_WORDS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RX,
    ST_DROP,
    ST_WB
  } rxdma_state_e;

  function automatic logic [WORD_W-1:0] pack_status(input logic [LEN_W-1:0] len,
                                                    input logic trunc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[TRUNC_BIT]        = trunc;
    w[OWN_BIT]          = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxdma_len_track.sv
module rxdma_len_track import rxdma_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] size_i,
  output logic             store_o,
  output logic             last_slot_o,
  output logic [LEN_W-1:0] len_o,
  output logic             trunc_o
);
  localparam int unsigned CW = LEN_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] size_ext;

  assign size_ext    = CW'(size_i);
  assign store_o     = cnt_q < size_ext;
  assign last_slot_o = (cnt_q + CW'(1)) == size_ext;
  assign trunc_o     = cnt_q > size_ext;
  assign len_o       = trunc_o ? size_i : cnt_q[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))     cnt_q <= cnt_q + CW'(1);
  end

  // R6: a reported length never exceeds the buffer size
  p_len_clamped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(len_o) <= size_ext);
endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer import rxdma_pkg::*; #(
  parameter int unsigned OFF_W = LEN_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  input  logic              flush_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [LANE_W-1:0]   lane_q;
  logic [WORD_W-9:0]   acc_q;
  logic [OFF_W-1:0]    off_q;
  logic [WORD_W-1:0]   merged;

  assign merged  = {8'h00, acc_q} | (WORD_W'(byte_i) << (8 * lane_q));
  assign wr_o    = push_i && ((lane_q == LANE_W'(LANES - 1)) || flush_i);
  assign wdata_o = merged;
  assign off_o   = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      acc_q  <= '0;
      off_q  <= '0;
    end else if (clr_i) begin
      lane_q <= '0;
      acc_q  <= '0;
      off_q  <= '0;
    end else if (push_i) begin
      if (wr_o) begin
        lane_q <= '0;
        acc_q  <= '0;
        off_q  <= off_q + OFF_W'(1);
      end else begin
        lane_q <= lane_q + LANE_W'(1);
        acc_q  <= merged[WORD_W-9:0];
      end
    end
  end

  // R3: after a word is emitted the next byte starts at lane 0
  p_lane_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !clr_i) |=> (lane_q == '0));
endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer import rxdma_pkg::*; #(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [AW-1:0]     ring_base_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              rx_drop_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int unsigned OFF_W = LEN_W - 2;
  localparam int unsigned FI_W  = $clog2(DESC_WORDS + 1);

  rxdma_state_e     state_q;
  logic [FI_W-1:0]  fidx_q;
  logic [AW-1:0]    cur_q, buf_q, next_q;
  logic             own_q, active_q, drop_q;
  logic [LEN_W-1:0] size_q;

  logic             hs, own_hs, first_drop, fetch_go, wb_go;
  logic             lt_store, lt_last_slot, lt_trunc;
  logic [LEN_W-1:0] lt_len;
  logic             pk_wr;
  logic [WORD_W-1:0] pk_wdata;
  logic [OFF_W-1:0] pk_off;
  logic [AW-1:0]    pk_addr;

  assign in_ready_o = (state_q == ST_RX) || (state_q == ST_DROP);
  assign hs         = in_valid_i && in_ready_o;
  assign own_hs     = hs && (state_q == ST_RX) && (active_q || own_q);
  assign first_drop = hs && (state_q == ST_RX) && !active_q && !own_q;
  assign fetch_go   = (state_q == ST_FETCH) && (fidx_q < FI_W'(DESC_WORDS))
                      && ((fidx_q != '0) || run_i);
  assign wb_go      = (state_q == ST_WB);
  assign rx_drop_o  = drop_q;

  rxdma_len_track u_len (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (wb_go),
    .inc_i       (own_hs),
    .size_i      (size_q),
    .store_o     (lt_store),
    .last_slot_o (lt_last_slot),
    .len_o       (lt_len),
    .trunc_o     (lt_trunc)
  );

  rxdma_packer #(.OFF_W(OFF_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wb_go),
    .push_i  (own_hs && lt_store),
    .byte_i  (in_data_i),
    .flush_i (in_last_i || lt_last_slot),
    .wr_o    (pk_wr),
    .wdata_o (pk_wdata),
    .off_o   (pk_off)
  );

  assign pk_addr = buf_q + AW'({pk_off, 2'b00});

  always_comb begin
    mem_req_o   = fetch_go || pk_wr || wb_go;
    mem_we_o    = pk_wr || wb_go;
    mem_wdata_o = wb_go ? pack_status(lt_len, lt_trunc) : pk_wdata;
    if (wb_go)      mem_addr_o = cur_q;
    else if (pk_wr) mem_addr_o = pk_addr;
    else            mem_addr_o = cur_q + AW'({fidx_q, 2'b00});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fidx_q   <= '0;
      cur_q    <= '0;
      buf_q    <= '0;
      next_q   <= '0;
      own_q    <= 1'b0;
      active_q <= 1'b0;
      drop_q   <= 1'b0;
      size_q   <= '0;
    end else begin
      drop_q <= first_drop;
      unique case (state_q)
        ST_IDLE: begin
          if (run_i) begin
            cur_q   <= ring_base_i;
            fidx_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if ((fidx_q == '0) && !run_i) begin
            state_q <= ST_IDLE;
          end else begin
            fidx_q <= fidx_q + FI_W'(1);
            case (fidx_q)
              FI_W'(1): own_q  <= mem_rdata_i[OWN_BIT];
              FI_W'(2): size_q <= mem_rdata_i[LEN_W-1:0];
              FI_W'(3): buf_q  <= AW'(mem_rdata_i);
              FI_W'(4): begin
                next_q  <= AW'(mem_rdata_i);
                fidx_q  <= '0;
                state_q <= ST_RX;
              end
              default: ;
            endcase
          end
        end
        ST_RX: begin
          if (first_drop) begin
            state_q <= in_last_i ? ST_FETCH : ST_DROP;
          end else if (own_hs) begin
            active_q <= !in_last_i;
            if (in_last_i) state_q <= ST_WB;
          end else if (!active_q && !in_valid_i && (!own_q || !run_i)) begin
            // re-poll a software-owned descriptor, or leave when stopped
            state_q <= ST_FETCH;
          end
        end
        ST_DROP: begin
          if (hs && in_last_i) state_q <= ST_FETCH;
        end
        ST_WB: begin
          cur_q   <= next_q;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!mem_req_o && !in_ready_o));

  p_read_stalls_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !in_ready_o);

  p_wb_stalls_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_go |-> (mem_we_o && !in_ready_o && (mem_addr_o == cur_q)));

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_go |-> (!mem_wdata_o[OWN_BIT] && (mem_wdata_o[LEN_LSB +: LEN_W] <= size_q)));

  p_in_bounds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_wr |-> ({pk_off, 2'b00} < size_q));

  p_drop_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |-> !mem_we_o);

  p_drop_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_o |=> !rx_drop_o);
endmodule

// File: tb/rxdma_writer_tb_top.sv
module rxdma_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] ring_base = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, rx_drop, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  int drop_seen = 0;

  logic [31:0] mem [0:1023];

  always #5 clk = ~clk;

  rxdma_writer #(.AW(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .ring_base_i(ring_base),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .rx_drop_o(rx_drop),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
  end

  // behavioural reference model
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  int          q_kind[$];   // 0 data word, 1 status word
  logic [31:0] m_cur = '0;
  bit          m_active = 0, m_drop = 0, exp_drop = 0;
  int          m_cnt, m_size, m_lane;
  logic [31:0] m_buf, m_acc;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(rx_drop == exp_drop, "R7 drop pulse", 32'(rx_drop), 32'(exp_drop));
      if (rx_drop) drop_seen++;
      exp_drop = 0;
      if (in_valid && in_ready) begin
        if (!m_active && !m_drop) begin
          if (!mem[m_cur[11:2]][31]) begin
            m_drop = 1; exp_drop = 1;
          end else begin
            m_active = 1; m_cnt = 0; m_lane = 0; m_acc = '0;
            m_size = int'(mem[m_cur[11:2] + 1][13:0]);
            m_buf  = mem[m_cur[11:2] + 2];
          end
        end
        if (m_drop) begin
          if (in_last) m_drop = 0;
        end else begin
          if (m_cnt < m_size) begin
            m_acc = m_acc | (32'(in_data) << (8 * m_lane));
            m_lane++;
            if (m_lane == 4 || in_last || m_cnt + 1 == m_size) begin
              q_addr.push_back(m_buf + 32'(4 * (m_cnt / 4)));
              q_data.push_back(m_acc); q_kind.push_back(0);
              m_acc = '0; m_lane = 0;
            end
          end
          m_cnt++;
          if (in_last) begin
            q_addr.push_back(m_cur);
            q_data.push_back((32'((m_cnt > m_size) ? m_size : m_cnt) << 16)
                             | 32'(m_cnt > m_size));
            q_kind.push_back(1);
            m_cur = mem[m_cur[11:2] + 3];
            m_active = 0;
          end
        end
      end
      if (mem_req && mem_we) begin
        if (q_kind.size() == 0) begin
          check(0, "R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed; int k;
          ea = q_addr.pop_front(); ed = q_data.pop_front(); k = q_kind.pop_front();
          check(mem_addr == ea, k ? "R4 status addr" : "R3 data addr", mem_addr, ea);
          check(mem_wdata == ed, k ? "R4 status word" : "R3 data word", mem_wdata, ed);
          if (k == 1) check(!in_ready, "R10 ready during writeback", 32'(in_ready), 0);
        end
      end else if (mem_req) begin
        check(mem_addr >= m_cur && mem_addr <= m_cur + 12 && mem_addr[1:0] == 2'b00,
              "R2 descriptor read addr", mem_addr, m_cur);
        check(!in_ready, "R10 ready during read", 32'(in_ready), 0);
      end
    end
  end

  task automatic put_byte(input logic [7:0] b, input logic l);
    in_valid = 1'b1; in_data = b; in_last = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] first, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin @(posedge clk); #1; end
      put_byte(first + 8'(i), i == n - 1);
    end
  endtask

  task automatic drain();
    while (q_kind.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_A5A5;
    mem[0] = 32'h8000_0000; mem[1] = 32'd40; mem[2] = 32'h100; mem[3] = 32'h010;
    mem[4] = 32'h8000_0000; mem[5] = 32'd6;  mem[6] = 32'h200; mem[7] = 32'h020;
    mem[8] = 32'h8000_0000; mem[9] = 32'd8;  mem[10] = 32'h300; mem[11] = 32'h000;

    repeat (3) @(negedge clk);
    check(!in_ready, "R1 reset ready", 32'(in_ready), 0);
    check(!mem_req, "R1 reset mem_req", 32'(mem_req), 0);
    check(!rx_drop, "R1 reset drop", 32'(rx_drop), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!mem_req && !in_ready, "R1 idle quiet", 32'(mem_req), 0);
    end

    @(posedge clk); #1;
    ring_base = 32'h0; m_cur = 32'h0; run = 1'b1;
    send_frame(13, 8'h10, 0);                 // R3 partial word, R5 runt
    drain();
    check(mem[0] == (32'd13 << 16), "R5 runt length", mem[0], 32'd13 << 16);

    send_frame(10, 8'h20, 0);                 // R6 truncated at 6
    drain();
    check(mem[4] == ((32'd6 << 16) | 32'd1), "R6 clamp and flag", mem[4],
          (32'd6 << 16) | 32'd1);
    check(mem[(32'h208) >> 2] == 32'hA5A5_A5A5, "R6 no write past size",
          mem[(32'h208) >> 2], 32'hA5A5_A5A5);

    send_frame(8, 8'h30, 1);                  // R6 exact size
    drain();
    check(mem[8] == (32'd8 << 16), "R6 exact size no flag", mem[8], 32'd8 << 16);

    send_frame(5, 8'h50, 0);                  // R7 ring wrapped to owned-by-software desc0
    drain();
    check(drop_seen == 1, "R7 one drop pulse", 32'(drop_seen), 1);
    check(mem[(32'h100) >> 2] == 32'h1312_1110, "R7 buffer untouched",
          mem[(32'h100) >> 2], 32'h1312_1110);

    mem[0] = 32'h8000_0000; mem[4] = 32'h8000_0000; mem[8] = 32'h8000_0000;
    repeat (20) @(posedge clk); #1;
    send_frame(20, 8'h40, 1);                 // R8 retry lands in desc0 after wrap
    drain();
    check(mem[0] == (32'd20 << 16), "R8 wrapped descriptor status", mem[0], 32'd20 << 16);

    run = 1'b0;
    repeat (20) @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!mem_req && !in_ready, "R9 stopped quiet", 32'(mem_req), 0);
    end
    @(posedge clk); #1;
    ring_base = 32'h020; m_cur = 32'h020; run = 1'b1;
    send_frame(4, 8'h70, 0);
    drain();
    check(mem[(32'h300) >> 2] == 32'h7372_7170, "R9 restart at new base",
          mem[(32'h300) >> 2], 32'h7372_7170);
    check(mem[8] == (32'd4 << 16), "R9 restart status", mem[8], 32'd4 << 16);
    check(q_kind.size() == 0, "R4 all writes seen", 32'(q_kind.size()), 0);
    finish_run();
  end
endmodule